// File: doc/BRIEF.md
# Flash Command Status Reporter

This block is the host-facing control logic of a parallel NOR-style flash device, reduced to a small synchronous model. The host drives a write strobe with a word address and data, and a read strobe with an address. The block watches the write cycles for unlock-and-command sequences. It starts program and sector-erase operations, and it lets the host suspend an erase, program another location, and then resume the erase. A register array stands in for the cell array. Fixed cycle counts stand in for the time an operation takes.

While an operation is in flight, a read does not return array data. It returns a status pattern on data bits 7, 6 and 2. The pattern depends on the operating state and on which address is being read. Two of those status bits flip on every read, so the host can poll until they stop changing. A ready output stays low while the device is busy and also while reset is held. A width-select input chooses between 16-bit word access and 8-bit byte access. In byte mode an extra address line picks the byte lane, and only the low byte lines are driven.

Top module: `flash_status_ctl`

## Requirements
- R1: While `rst_n` is low, `ready` is 0. After reset the block is in array-read mode with `ready` at 1. A program cut short by reset leaves the array unchanged.
- R2: A program starts from four writes: word address 5 with data AA, address 10 with data 55, address 5 with data A0, then any write, which supplies the target address and data. `ready` is low from the cycle after the fourth write for PROG_CYC cycles. The data is then stored and `ready` returns high.
- R3: A sector erase starts from six writes: 5/AA, 10/55, 5/80, 5/AA, 10/55, then data 30 at an address inside the target sector. The sector is the top SECT_W bits of the word address. `ready` is low for ERASE_CYC cycles, and every word of the sector then reads FFFF.
- R4: A write whose address or data does not match the next expected step drops the partial sequence. The block goes back to waiting for the first step.
- R5: While a program is busy, all writes are ignored. While an erase is busy, every write other than the suspend command (data B0) is ignored.
- R6: During a program, a read returns bit 7 as the complement of bit 7 of the data being written, bit 6 as a toggling value, and bit 2 as 1. All other bits read 0.
- R7: During an erase, a read returns bit 7 as 0, with bits 6 and 2 toggling. All other bits read 0.
- R8: Writing B0 during an erase suspends it. `ready` goes high on the next cycle. A read in the suspended sector returns bits 7 and 6 as 1, with bit 2 toggling. Reads elsewhere return array data. Writing 30 resumes the erase, which then completes.
- R9: A program issued while an erase is suspended runs with `ready` low. A read returns bit 7 as the complement of data bit 7, and bit 6 toggles. Bit 2 reads 1 at the address being programmed and toggles for reads in the suspended sector. When the program ends, the block returns to the suspended state.
- R10: Each status toggle bit changes once per read cycle in which it is shown, so two back-to-back reads differ.
- R11: When `word_mode` is 0, the byte address is {`addr`, `addr_lsb`}, with `addr_lsb`=1 selecting bits 15:8 of the word. Reads place the byte on bits 7:0, and `rdata_oe` is 00FF. When `word_mode` is 1 and reading, `rdata_oe` is FFFF. Without a read it is 0000.
- R12: Command decoding uses only `wdata[7:0]`. Bits 15:8 have no effect on a command cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| word_mode | input | 1 | 1: 16-bit access, 0: 8-bit access |
| addr | input | ADDR_W | Word address |
| addr_lsb | input | 1 | Byte-lane select in byte mode |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| rd_en | input | 1 | Read strobe, one cycle per bus read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data or status |
| rdata_oe | output | 16 | Per-bit drive enable of read data |
| ready | output | 1 | 1: ready, 0: busy or in reset |

## Verification
The hardest state to reach is a program running inside a suspended erase. There, bit 2 must read 1 at the programmed address, toggle for reads in the suspended sector, and bit 6 must keep alternating. The stimulus starts a sector erase and suspends it on the very next write. It then issues a full program sequence and reads the programmed address and then two suspended-sector addresses back to back, all before the program counter expires. Once that program ends, the bench confirms the block is still suspended before it resumes the erase.

// File: rtl/flash_status_ctl.sv
module flash_status_ctl #(
  parameter int ADDR_W    = 4,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addr_lsb,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic [15:0]       rdata_oe,
  output logic              ready
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int PC_W  = $clog2(PROG_CYC + 1);
  localparam int EC_W  = $clog2(ERASE_CYC + 1);
  localparam logic [ADDR_W-1:0] UNLK_A = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] UNLK_B = ADDR_W'(10);
  localparam logic [PC_W-1:0] P_LAST = PC_W'(PROG_CYC - 1);
  localparam logic [EC_W-1:0] E_LAST = EC_W'(ERASE_CYC - 1);
  localparam logic [2:0] M_READ = 3'd0, M_PROG = 3'd1, M_ERASE = 3'd2,
                         M_SUSP = 3'd3, M_SPROG = 3'd4;

  logic [2:0]        mode, step, nstep;
  logic [15:0]       mem [WORDS];
  logic [ADDR_W-1:0] p_addr;
  logic              p_lsb, p_word;
  logic [15:0]       p_data;
  logic [SECT_W-1:0] e_sect;
  logic [PC_W-1:0]   pcnt;
  logic [EC_W-1:0]   ecnt;
  logic              tog6, tog2;
  logic [7:0]        stat;
  logic [15:0]       arr;

  wire [7:0]        cmd      = wdata[7:0];
  wire [SECT_W-1:0] sect     = addr[ADDR_W-1 -: SECT_W];
  wire              at_a     = addr == UNLK_A;
  wire              at_b     = addr == UNLK_B;
  wire              in_esect = sect == e_sect;
  wire              at_paddr = addr == p_addr;
  wire              prog_on  = mode == M_PROG || mode == M_SPROG;
  wire              suspend  = mode == M_ERASE && wr_en && cmd == 8'hB0;
  wire              p_done   = prog_on && pcnt == P_LAST;
  wire              e_done   = mode == M_ERASE && !suspend && ecnt == E_LAST;
  wire              adv6     = prog_on || mode == M_ERASE;
  wire              adv2     = mode == M_ERASE || (mode == M_SUSP && in_esect) ||
                               (mode == M_SPROG && in_esect && !at_paddr);

  always_comb begin
    nstep = 3'd0;
    case (step)
      3'd0: if (at_a && cmd == 8'hAA) nstep = 3'd1;
      3'd1: if (at_b && cmd == 8'h55) nstep = 3'd2;
      3'd2: if (at_a && cmd == 8'hA0) nstep = 3'd3;
            else if (at_a && cmd == 8'h80 && mode == M_READ) nstep = 3'd4;
      3'd4: if (at_a && cmd == 8'hAA) nstep = 3'd5;
      3'd5: if (at_b && cmd == 8'h55) nstep = 3'd6;
      default: nstep = 3'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_READ; step <= 3'd0; pcnt <= '0; ecnt <= '0;
      tog6 <= 1'b0; tog2 <= 1'b0; e_sect <= '0;
      p_addr <= '0; p_lsb <= 1'b0; p_word <= 1'b1; p_data <= '0;
    end else begin
      if (rd_en && adv6) tog6 <= ~tog6;
      if (rd_en && adv2) tog2 <= ~tog2;
      case (mode)
        M_READ, M_SUSP: if (wr_en) begin
          step <= nstep;
          if (step == 3'd3) begin
            p_addr <= addr; p_lsb <= addr_lsb; p_word <= word_mode; p_data <= wdata;
            pcnt <= '0;
            mode <= (mode == M_SUSP) ? M_SPROG : M_PROG;
          end else if (step == 3'd6 && cmd == 8'h30) begin
            e_sect <= sect; ecnt <= '0; mode <= M_ERASE;
          end else if (mode == M_SUSP && step == 3'd0 && cmd == 8'h30) begin
            mode <= M_ERASE;
          end
        end
        M_PROG, M_SPROG: if (p_done) mode <= (mode == M_SPROG) ? M_SUSP : M_READ;
                         else pcnt <= pcnt + 1'b1;
        M_ERASE: if (suspend) mode <= M_SUSP;
                 else if (e_done) mode <= M_READ;
                 else ecnt <= ecnt + 1'b1;
        default: mode <= M_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (p_done) begin
      if (p_word)     mem[p_addr]       <= p_data;
      else if (p_lsb) mem[p_addr][15:8] <= p_data[7:0];
      else            mem[p_addr][7:0]  <= p_data[7:0];
    end
    if (e_done)
      for (int i = 0; i < WORDS; i++)
        if (SECT_W'(i >> (ADDR_W - SECT_W)) == e_sect) mem[ADDR_W'(i)] <= 16'hFFFF;
  end

  assign arr = word_mode ? mem[addr]
                         : {8'h00, addr_lsb ? mem[addr][15:8] : mem[addr][7:0]};

  always_comb begin
    case (mode)
      M_PROG:  stat = {~p_data[7], tog6, 3'b000, 1'b1, 2'b00};
      M_ERASE: stat = {1'b0, tog6, 3'b000, tog2, 2'b00};
      M_SUSP:  stat = {1'b1, 1'b1, 3'b000, tog2, 2'b00};
      default: stat = {~p_data[7], tog6, 3'b000, (at_paddr || !in_esect) ? 1'b1 : tog2, 2'b00};
    endcase
  end

  assign rdata    = (mode == M_READ || (mode == M_SUSP && !in_esect)) ? arr : {8'h00, stat};
  assign rdata_oe = !rd_en ? 16'h0000 : (word_mode ? 16'hFFFF : 16'h00FF);
  assign ready    = rst_n && !(prog_on || mode == M_ERASE);
endmodule

// File: rtl/flash_status_ctl_chk.sv
module flash_status_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic        wr_en,
  input logic        word_mode,
  input logic [7:0]  cmd,
  input logic [2:0]  mode,
  input logic [15:0] rdata,
  input logic [15:0] rdata_oe,
  input logic        ready
);
  a_r1_busy_in_reset: assert property (@(posedge clk) !rst_n |-> !ready);

  a_r11_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata_oe == 16'h0000);

  a_r11_byte_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !word_mode) |-> rdata_oe == 16'h00FF);

  a_r7_erase_dq7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == 3'd2) |-> !rdata[7]);

  a_r10_dq6_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == 3'd1) ##1 (rd_en && mode == 3'd1) |-> rdata[6] != $past(rdata[6]));

  a_r8_suspend_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd == 8'hB0 && mode == 3'd2) |=> ready);
endmodule

bind flash_status_ctl flash_status_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .word_mode(word_mode),
  .cmd(wdata[7:0]), .mode(mode), .rdata(rdata), .rdata_oe(rdata_oe), .ready(ready)
);

// File: tb/flash_status_ctl_tb.sv
module flash_status_ctl_tb;
  logic clk = 1'b0, rst_n = 1'b0, word_mode = 1'b1, addr_lsb = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wdata = '0, rdata, rdata_oe, rv, roe, a, b, c;
  logic ready;
  int nchk = 0, nerr = 0, n;

  flash_status_ctl u_dut (.clk(clk), .rst_n(rst_n), .word_mode(word_mode), .addr(addr),
    .addr_lsb(addr_lsb), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .rdata_oe(rdata_oe), .ready(ready));

  always #5 clk = ~clk;

  // op[37:36]: 0 write, 1 read and compare, 2 wait for ready; addr[35:32]; data[31:16]; expect[15:0]
  localparam logic [37:0] VEC [22] = '{
    {2'd0, 4'h5, 16'h00AA, 16'h0}, {2'd0, 4'hA, 16'h0055, 16'h0},
    {2'd0, 4'h5, 16'h0080, 16'h0}, {2'd0, 4'h5, 16'h00AA, 16'h0},
    {2'd0, 4'hA, 16'h0055, 16'h0}, {2'd0, 4'h4, 16'hFF30, 16'h0},
    {2'd2, 4'h0, 16'h0000, 16'h0}, {2'd1, 4'h4, 16'h0000, 16'hFFFF},
    {2'd1, 4'h7, 16'h0000, 16'hFFFF}, {2'd0, 4'h5, 16'h12AA, 16'h0},
    {2'd0, 4'hA, 16'h0055, 16'h0}, {2'd0, 4'h5, 16'h00A0, 16'h0},
    {2'd0, 4'h5, 16'h1234, 16'h0}, {2'd2, 4'h0, 16'h0000, 16'h0},
    {2'd1, 4'h5, 16'h0000, 16'h1234}, {2'd1, 4'h6, 16'h0000, 16'hFFFF},
    {2'd0, 4'h5, 16'h00AA, 16'h0}, {2'd0, 4'h3, 16'h0055, 16'h0},
    {2'd0, 4'h5, 16'h00A0, 16'h0}, {2'd0, 4'h5, 16'h0000, 16'h0},
    {2'd1, 4'h5, 16'h0000, 16'h1234}, {2'd1, 4'h6, 16'h0000, 16'hFFFF}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] ad, input logic [15:0] d);
    addr = ad; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] ad);
    addr = ad; rd_en = 1'b1;
    #2 rv = rdata; roe = rdata_oe;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_ready(output int cnt);
    cnt = 0;
    while (!ready) begin @(negedge clk); cnt++; end
  endtask

  task automatic prog_seq(input logic [3:0] ad, input logic [15:0] d);
    wr(4'h5, 16'h00AA); wr(4'hA, 16'h0055); wr(4'h5, 16'h00A0); wr(ad, d);
  endtask

  task automatic erase_seq(input logic [3:0] ad);
    wr(4'h5, 16'h00AA); wr(4'hA, 16'h0055); wr(4'h5, 16'h0080);
    wr(4'h5, 16'h00AA); wr(4'hA, 16'h0055); wr(ad, 16'h0030);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 ready low in reset", {15'd0, ready}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {15'd0, ready}, 16'd1);

    for (int i = 0; i < 22; i++) begin
      case (VEC[i][37:36])
        2'd0: wr(VEC[i][35:32], VEC[i][31:16]);
        2'd1: begin
          rd(VEC[i][35:32]);
          chk($sformatf("R2 R3 R4 R12 table vector %0d", i), rv, VEC[i][15:0]);
        end
        default: wait_ready(n);
      endcase
    end

    // R2 busy window and store
    prog_seq(4'h6, 16'h00F0);
    chk("R2 busy after fourth write", {15'd0, ready}, 16'd0);
    wait_ready(n);
    chk("R2 busy cycles", 16'(n), 16'd8);
    rd(4'h6); chk("R2 stored word", rv, 16'h00F0);

    // R6 / R10 program status, R5 writes ignored while programming
    prog_seq(4'h7, 16'h0F8F);
    rd(4'h3); a = rv;
    rd(4'h3); b = rv;
    chk("R6 program status bits", a & ~16'h0040, 16'h0004);
    chk("R10 dq6 alternates in program", {15'd0, a[6] ^ b[6]}, 16'd1);
    prog_seq(4'h4, 16'h0000);
    wait_ready(n);
    rd(4'h7); chk("R2 second store", rv, 16'h0F8F);
    rd(4'h4); chk("R5 program during busy ignored", rv, 16'hFFFF);

    // R3 erase timing
    erase_seq(4'h8);
    chk("R3 busy after sixth write", {15'd0, ready}, 16'd0);
    wait_ready(n);
    chk("R3 erase cycles", 16'(n), 16'd12);
    rd(4'h9); chk("R3 sector erased", rv, 16'hFFFF);

    // R7 erase status, R5 writes ignored during erase
    erase_seq(4'h8);
    rd(4'h0); a = rv;
    rd(4'h0); b = rv;
    chk("R7 erase status bits", a & ~16'h0044, 16'h0000);
    chk("R7 dq6 and dq2 toggle", {14'd0, a[6] ^ b[6], a[2] ^ b[2]}, 16'd3);
    prog_seq(4'h8, 16'h0000);
    wait_ready(n);
    rd(4'h8); chk("R5 program during erase ignored", rv, 16'hFFFF);

    // R8 suspend / R9 suspend program
    erase_seq(4'h0);
    wr(4'h0, 16'h00B0);
    chk("R8 ready after suspend", {15'd0, ready}, 16'd1);
    rd(4'h0); a = rv;
    rd(4'h1); b = rv;
    chk("R8 suspended sector status", a & ~16'h0004, 16'h00C0);
    chk("R8 dq2 toggles in suspended sector", {15'd0, a[2] ^ b[2]}, 16'd1);
    rd(4'h5); chk("R8 other sector reads array", rv, 16'h1234);
    prog_seq(4'h4, 16'h0055);
    chk("R9 busy in suspend program", {15'd0, ready}, 16'd0);
    rd(4'h4); a = rv;
    rd(4'h1); b = rv;
    rd(4'h2); c = rv;
    chk("R9 status at programmed address", a & ~16'h0040, 16'h0084);
    chk("R9 dq2 toggles in suspended sector", {15'd0, b[2] ^ c[2]}, 16'd1);
    chk("R10 dq6 alternates in suspend program", {14'd0, a[6] ^ b[6], b[6] ^ c[6]}, 16'd3);
    wait_ready(n);
    rd(4'h4); chk("R9 suspend program stored", rv, 16'h0055);
    rd(4'h0); chk("R9 returns to suspend", rv & ~16'h0004, 16'h00C0);
    wr(4'h0, 16'h0030);
    chk("R8 resume busy", {15'd0, ready}, 16'd0);
    wait_ready(n);
    rd(4'h3); chk("R8 resumed erase completes", rv, 16'hFFFF);
    rd(4'h5); chk("R8 other sector untouched", rv, 16'h1234);

    // R11 byte mode
    word_mode = 1'b0;
    wr(4'h5, 16'h00AA); wr(4'hA, 16'h0055); wr(4'h5, 16'h00A0);
    addr_lsb = 1'b1; wr(4'h7, 16'h00A5); addr_lsb = 1'b0;
    wait_ready(n);
    rd(4'h7); chk("R11 low byte read", rv, 16'h008F);
    chk("R11 byte mode drive", roe, 16'h00FF);
    addr_lsb = 1'b1; rd(4'h7); addr_lsb = 1'b0;
    chk("R11 upper byte written", rv, 16'h00A5);
    word_mode = 1'b1;
    rd(4'h7); chk("R11 word read", rv, 16'hA58F);
    chk("R11 word mode drive", roe, 16'hFFFF);
    #2 chk("R11 no drive when idle", rdata_oe, 16'h0000);
    @(negedge clk);

    // R1 reset during program
    prog_seq(4'h9, 16'h1111);
    @(negedge clk);
    rst_n = 1'b0;
    #2 chk("R1 ready low during reset", {15'd0, ready}, 16'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after mid-program reset", {15'd0, ready}, 16'd1);
    rd(4'h9); chk("R1 aborted program leaves array", rv, 16'hFFFF);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule